// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block keeps the time of day and the calendar date in packed BCD and moves them forward by one second on every pulse of the `tick` input. It cascades seconds into minutes, hours, day, month and a two-digit year. The day wraps according to the length of the month, with a 29th of February in every year divisible by four. A weekday field steps alongside the day.

Software uses four word registers selected by `addr`: 0 = time, 1 = date, 2 = status, 3 = control. Reads are combinational and always return shadow copies of the running counters. To set the clock, software first raises the init request. It waits for the init-mode flag, which means counting is frozen. It then writes time, date and the hour format, and drops the request. After that it clears the synchronization flag and waits for hardware to set it again, which marks the shadows as fresh.

Top module: `bcd_calendar`

## Requirements
- R1: Time word layout: seconds BCD in bits 6:0, minutes in bits 14:8, hours in bits 21:16, PM in bit 22. In 24-hour mode each accepted tick advances seconds. 59 wraps to 00 and carries into minutes; minutes wrap 59 to 00 into hours; hours wrap 23 to 00 into the day. Every field carries in decimal (09 is followed by 10).
- R2: Date word layout: day BCD in bits 5:0, month in bits 12:8, weekday in bits 15:13, year in bits 23:16. On a day carry the weekday steps 1..7 and returns to 1. The day wraps at 31 (months 01, 03, 05, 07, 08, 10, 12) or at 30 (months 04, 06, 09, 11) back to 01. Month 12 goes to 01, and year 99 goes to 00.
- R3: February ends after 29 when the year is divisible by four and after 28 otherwise.
- R4: Status bit 7 holds the init request as last written. Status bit 6 (init flag) rises exactly two cycles after the request is seen set. It falls one cycle after the request is seen cleared.
- R5: Ticks arriving while the init flag is set are dropped. Counting resumes with the first tick after the flag falls.
- R6: Writes to the time, date and control registers take effect only while the init flag is set and are otherwise ignored.
- R7: Status bit 5 (synchronized) is cleared by a status write with bit 5 = 0 and is held low while the init flag is set. It rises two cycles after it is cleared and the init flag is low.
- R8: Status bit 4 (initialized) is 0 after reset. It becomes 1 on the first accepted time or date write and then stays set.
- R9: Control bit 6 selects the hour format: 0 = 24-hour, 1 = 12-hour. In 12-hour mode the hours run 12, 01 .. 11. At 11 to 12 the PM bit toggles, and the day carries only on the PM to AM step. In 24-hour mode a loaded PM bit is dropped.
- R10: Writing all-zero time and date in init mode is accepted and reads back as zero.
- R11: After reset, time reads 0, date reads 0x00002101 (day 01, month 01, weekday 1, year 00), control reads 0, and status reads 0.
- R12: Register reads show the running counters with one cycle of delay through the shadow copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, one per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select (0 time, 1 date, 2 status, 3 control) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |

## Verification
The bench builds the block with the default settle delays of two cycles for both the init flag and the synchronized flag. These small counts make the exact rise and fall cycles of both flags observable at the ports. Because `tick` is a plain input, the bench loads values one second before each boundary: end of day, end of February in leap and common years, end of a 30-day month, end of year, and the 12-hour AM/PM turns. One tick then reaches each carry chain.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;

    localparam int STS_REQ   = 7;
    localparam int STS_FLAG  = 6;
    localparam int STS_SYNC  = 5;
    localparam int STS_INITD = 4;
    localparam int CTL_FMT   = 6;
    localparam int TOD_PM    = 22;

    typedef enum logic [ADDR_W-1:0] {
        SEL_TIME = 2'd0,
        SEL_DATE = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       pm;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } tod_t;

    typedef struct packed {
        logic [7:0] year;
        logic [2:0] wday;
        logic [4:0] month;
        logic [5:0] day;
    } ymd_t;

    localparam tod_t TOD_RST = '{pm: 1'b0, hour: 6'h00, min: 7'h00, sec: 7'h00};
    localparam ymd_t YMD_RST = '{year: 8'h00, wday: 3'd1, month: 5'h01, day: 6'h01};

    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic leap_year(input logic [7:0] y);
        logic l;
        if (!y[4]) l = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        else       l = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return l;
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
        logic [5:0] d;
        case (m)
            5'h02:                      d = leap_year(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
            default:                    d = 6'h31;
        endcase
        return d;
    endfunction

    function automatic logic [BUS_W-1:0] tod_pack(input tod_t t);
        return {9'd0, t.pm, t.hour, 1'b0, t.min, 1'b0, t.sec};
    endfunction

    function automatic logic [BUS_W-1:0] ymd_pack(input ymd_t d);
        return {8'd0, d.year, d.wday, d.month, 2'b00, d.day};
    endfunction

    function automatic tod_t tod_unpack(input logic [BUS_W-1:0] w, input logic h12);
        tod_t t;
        t.pm   = h12 & w[TOD_PM];
        t.hour = w[21:16];
        t.min  = w[14:8];
        t.sec  = w[6:0];
        return t;
    endfunction

    function automatic ymd_t ymd_unpack(input logic [BUS_W-1:0] w);
        ymd_t d;
        d.year  = w[23:16];
        d.wday  = w[15:13];
        d.month = w[12:8];
        d.day   = w[5:0];
        return d;
    endfunction

endpackage

// File: rtl/cal_settle.sv
module cal_settle #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = (DLY < 2) ? 1 : $clog2(DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (!run) cnt <= '0;
        else if (done) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cal_sync.sv
module cal_sync #(
    parameter int INIT_DLY = 2,
    parameter int SYNC_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sts_we,
    input  logic req_bit,
    input  logic sync_bit,
    input  logic cal_we,
    output logic req,
    output logic init_flag,
    output logic rsf,
    output logic initd
);
    logic init_done, sync_done, sync_clr, init_run, sync_run;

    assign sync_clr = sts_we && !sync_bit;
    assign init_run = req && !init_flag;
    assign sync_run = !rsf && !init_flag && !sync_clr;

    cal_settle #(.DLY(INIT_DLY)) u_init_dly (
        .clk(clk), .rst(rst), .run(init_run), .done(init_done)
    );

    cal_settle #(.DLY(SYNC_DLY)) u_sync_dly (
        .clk(clk), .rst(rst), .run(sync_run), .done(sync_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req       <= 1'b0;
            init_flag <= 1'b0;
            rsf       <= 1'b0;
            initd     <= 1'b0;
        end else begin
            if (sts_we) req <= req_bit;

            if (!req)           init_flag <= 1'b0;
            else if (init_done) init_flag <= 1'b1;

            if (init_flag || sync_clr) rsf <= 1'b0;
            else if (sync_done)        rsf <= 1'b1;

            if (cal_we) initd <= 1'b1;
        end
    end
endmodule

// File: rtl/cal_count.sv
module cal_count
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             mode12,
    input  logic             tod_we,
    input  logic             ymd_we,
    input  logic [BUS_W-1:0] wdata,
    output tod_t             tod,
    output ymd_t             ymd
);
    tod_t       tod_n;
    ymd_t       ymd_n;
    logic       day_step;
    logic [7:0] sec_i, min_i, hr_i, day_i, mon_i, yr_i;
    logic [5:0] last_day;

    always_comb begin
        sec_i    = bcd_next({1'b0, tod.sec});
        min_i    = bcd_next({1'b0, tod.min});
        hr_i     = bcd_next({2'b00, tod.hour});
        day_i    = bcd_next({2'b00, ymd.day});
        mon_i    = bcd_next({3'b000, ymd.month});
        yr_i     = bcd_next(ymd.year);
        last_day = month_last(ymd.month, ymd.year);
    end

    always_comb begin
        tod_n    = tod;
        day_step = 1'b0;
        if (adv) begin
            if (tod.sec == 7'h59) begin
                tod_n.sec = 7'h00;
                if (tod.min == 7'h59) begin
                    tod_n.min = 7'h00;
                    if (mode12) begin
                        if (tod.hour == 6'h11) begin
                            tod_n.hour = 6'h12;
                            tod_n.pm   = ~tod.pm;
                            day_step   = tod.pm;
                        end else if (tod.hour == 6'h12) begin
                            tod_n.hour = 6'h01;
                        end else begin
                            tod_n.hour = hr_i[5:0];
                        end
                    end else begin
                        tod_n.pm = 1'b0;
                        if (tod.hour == 6'h23) begin
                            tod_n.hour = 6'h00;
                            day_step   = 1'b1;
                        end else begin
                            tod_n.hour = hr_i[5:0];
                        end
                    end
                end else begin
                    tod_n.min = min_i[6:0];
                end
            end else begin
                tod_n.sec = sec_i[6:0];
            end
        end
    end

    always_comb begin
        ymd_n = ymd;
        if (day_step) begin
            ymd_n.wday = (ymd.wday == 3'd7) ? 3'd1 : ymd.wday + 3'd1;
            if (ymd.day == last_day) begin
                ymd_n.day = 6'h01;
                if (ymd.month == 5'h12) begin
                    ymd_n.month = 5'h01;
                    ymd_n.year  = (ymd.year == 8'h99) ? 8'h00 : yr_i;
                end else begin
                    ymd_n.month = mon_i[4:0];
                end
            end else begin
                ymd_n.day = day_i[5:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tod <= TOD_RST;
            ymd <= YMD_RST;
        end else begin
            tod <= tod_we ? tod_unpack(wdata, mode12) : tod_n;
            ymd <= ymd_we ? ymd_unpack(wdata) : ymd_n;
        end
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int INIT_DLY = 2,
    parameter int SYNC_DLY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata
);
    reg_sel_e         sel;
    logic             we_time, we_date, we_stat, we_ctrl;
    logic             tod_we, ymd_we, ctl_we;
    logic             req, init_flag, rsf, initd, fmt12;
    tod_t             live_tod;
    ymd_t             live_ymd;
    logic [BUS_W-1:0] live_tod_w, live_ymd_w, sh_tod_w, sh_ymd_w;

    assign sel     = reg_sel_e'(addr);
    assign we_time = wr_en && (sel == SEL_TIME);
    assign we_date = wr_en && (sel == SEL_DATE);
    assign we_stat = wr_en && (sel == SEL_STAT);
    assign we_ctrl = wr_en && (sel == SEL_CTRL);
    assign tod_we  = we_time && init_flag;
    assign ymd_we  = we_date && init_flag;
    assign ctl_we  = we_ctrl && init_flag;

    cal_sync #(.INIT_DLY(INIT_DLY), .SYNC_DLY(SYNC_DLY)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sts_we   (we_stat),
        .req_bit  (wdata[STS_REQ]),
        .sync_bit (wdata[STS_SYNC]),
        .cal_we   (tod_we || ymd_we),
        .req      (req),
        .init_flag(init_flag),
        .rsf      (rsf),
        .initd    (initd)
    );

    cal_count u_count (
        .clk   (clk),
        .rst   (rst),
        .adv   (tick && !init_flag),
        .mode12(fmt12),
        .tod_we(tod_we),
        .ymd_we(ymd_we),
        .wdata (wdata),
        .tod   (live_tod),
        .ymd   (live_ymd)
    );

    assign live_tod_w = tod_pack(live_tod);
    assign live_ymd_w = ymd_pack(live_ymd);

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt12    <= 1'b0;
            sh_tod_w <= tod_pack(TOD_RST);
            sh_ymd_w <= ymd_pack(YMD_RST);
        end else begin
            if (ctl_we) fmt12 <= wdata[CTL_FMT];
            sh_tod_w <= live_tod_w;
            sh_ymd_w <= live_ymd_w;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_TIME: rdata = sh_tod_w;
            SEL_DATE: rdata = sh_ymd_w;
            SEL_STAT: begin
                rdata[STS_REQ]   = req;
                rdata[STS_FLAG]  = init_flag;
                rdata[STS_SYNC]  = rsf;
                rdata[STS_INITD] = initd;
            end
            default:  rdata[CTL_FMT] = fmt12;
        endcase
    end
endmodule

// File: rtl/cal_chk.sv
module cal_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        req,
    input logic        init_flag,
    input logic        rsf,
    input logic        initd,
    input logic        tod_we,
    input logic        ymd_we,
    input logic [31:0] live_tod_w,
    input logic [31:0] live_ymd_w
);
    // R4
    init_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(init_flag) |-> (req && $past(req)));

    // R4
    init_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> !init_flag);

    // R5
    freeze_tod_chk: assert property (@(posedge clk) disable iff (rst)
        (init_flag && !tod_we) |=> $stable(live_tod_w));

    // R5
    freeze_ymd_chk: assert property (@(posedge clk) disable iff (rst)
        (init_flag && !ymd_we) |=> $stable(live_ymd_w));

    // R6
    guard_tod_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_flag && !tick) |=> $stable(live_tod_w));

    // R7
    sync_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rsf) |-> !$past(init_flag));

    // R8
    initd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        initd |=> initd);
endmodule

bind bcd_calendar cal_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .req       (req),
    .init_flag (init_flag),
    .rsf       (rsf),
    .initd     (initd),
    .tod_we    (tod_we),
    .ymd_we    (ymd_we),
    .live_tod_w(live_tod_w),
    .live_ymd_w(live_ymd_w)
);

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    localparam logic [1:0] A_TIME = 2'd0, A_DATE = 2'd1, A_STAT = 2'd2, A_CTRL = 2'd3;

    always #4 clk = ~clk;

    bcd_calendar u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_cal(input logic h12, input logic [31:0] t, input logic [31:0] d);
        bus_wr(A_STAT, 32'h80);
        repeat (2) @(negedge clk);
        bus_wr(A_CTRL, h12 ? 32'h40 : 32'h0);
        bus_wr(A_TIME, t);
        bus_wr(A_DATE, d);
        bus_wr(A_STAT, 32'h0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(A_STAT, v); check("R11 status", v, 32'h0);
        rd(A_TIME, v); check("R11 time", v, 32'h0);
        rd(A_DATE, v); check("R11 date", v, 32'h00002101);
        rd(A_CTRL, v); check("R11 ctrl", v, 32'h0);
        @(negedge clk);
        rd(A_STAT, v); check("R7 sync after reset", v, 32'h20);
    endtask

    task automatic t_guard();
        logic [31:0] v;
        bus_wr(A_TIME, 32'h00123456);
        bus_wr(A_DATE, 32'h00991231);
        bus_wr(A_CTRL, 32'h40);
        repeat (2) @(negedge clk);
        rd(A_TIME, v); check("R6 time ignored", v, 32'h0);
        rd(A_DATE, v); check("R6 date ignored", v, 32'h00002101);
        rd(A_CTRL, v); check("R6 ctrl ignored", v, 32'h0);
        rd(A_STAT, v); check("R8 initd clear", v & 32'h10, 32'h0);
    endtask

    task automatic t_handshake();
        logic [31:0] v;
        bus_wr(A_STAT, 32'hA0);
        rd(A_STAT, v); check("R4 req set flag low", v & 32'hC0, 32'h80);
        @(negedge clk);
        rd(A_STAT, v); check("R4 flag low cycle 1", v & 32'hC0, 32'h80);
        @(negedge clk);
        rd(A_STAT, v); check("R4 flag high cycle 2", v & 32'hC0, 32'hC0);
        @(negedge clk);
        rd(A_STAT, v); check("R7 sync low in init", v & 32'h20, 32'h0);
        bus_wr(A_TIME, 32'h00095959);
        rd(A_TIME, v); check("R12 shadow lags", v, 32'h0);
        @(negedge clk);
        rd(A_TIME, v); check("R12 shadow updated", v, 32'h00095959);
        bus_wr(A_DATE, 32'h00254430);
        pulse_tick();
        rd(A_TIME, v); check("R5 tick dropped in init", v, 32'h00095959);
        rd(A_STAT, v); check("R8 initd set", v & 32'h10, 32'h10);
        bus_wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R4 flag still high", v & 32'hC0, 32'h40);
        @(negedge clk);
        rd(A_STAT, v); check("R4 flag fell", v & 32'hC0, 32'h0);
        @(negedge clk);
        rd(A_STAT, v); check("R7 sync pending", v & 32'h20, 32'h0);
        @(negedge clk);
        rd(A_STAT, v); check("R7 sync back", v & 32'h20, 32'h20);
        pulse_tick();
        rd(A_TIME, v); check("R5 R1 resume hour carry", v, 32'h00100000);
        rd(A_DATE, v); check("R2 date held", v, 32'h00254430);
    endtask

    task automatic t_sync();
        logic [31:0] v;
        bus_wr(A_STAT, 32'h20);
        rd(A_STAT, v); check("R7 write one keeps", v & 32'h30, 32'h30);
        bus_wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R7 cleared", v & 32'h20, 32'h0);
        @(negedge clk);
        rd(A_STAT, v); check("R7 still low", v & 32'h20, 32'h0);
        @(negedge clk);
        rd(A_STAT, v); check("R7 set again", v & 32'h20, 32'h20);
        rd(A_STAT, v); check("R8 initd kept", v & 32'h10, 32'h10);
    endtask

    task automatic roll(input string tag, input logic h12,
                        input logic [31:0] t0, input logic [31:0] d0,
                        input logic [31:0] t1, input logic [31:0] d1);
        logic [31:0] v;
        load_cal(h12, t0, d0);
        pulse_tick();
        rd(A_TIME, v); check({tag, " time"}, v, t1);
        rd(A_DATE, v); check({tag, " date"}, v, d1);
    endtask

    task automatic t_roll24();
        roll("R1 minute carry", 1'b0, 32'h00000959, 32'h00254430, 32'h00001000, 32'h00254430);
        roll("R3 common feb", 1'b0, 32'h00235959, 32'h0023E228, 32'h0, 32'h00232301);
        roll("R3 leap feb", 1'b0, 32'h00235959, 32'h0024E228, 32'h0, 32'h00242229);
        roll("R2 april end", 1'b0, 32'h00235959, 32'h00254430, 32'h0, 32'h00256501);
        roll("R2 year end", 1'b0, 32'h00235959, 32'h00997231, 32'h0, 32'h00008101);
    endtask

    task automatic t_12h();
        logic [31:0] v;
        roll("R9 pm to am", 1'b1, 32'h00515959, 32'h00254430, 32'h00120000, 32'h00256501);
        rd(A_CTRL, v); check("R9 ctrl fmt", v, 32'h40);
        roll("R9 am to pm", 1'b1, 32'h00115959, 32'h00254430, 32'h00520000, 32'h00254430);
        roll("R9 twelve to one", 1'b1, 32'h00125959, 32'h00254430, 32'h00010000, 32'h00254430);
        roll("R9 pm dropped 24h", 1'b0, 32'h00401059, 32'h00254430, 32'h00001100, 32'h00254430);
        rd(A_CTRL, v); check("R9 ctrl 24h", v, 32'h0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        load_cal(1'b0, 32'h0, 32'h0);
        rd(A_TIME, v); check("R10 zero time", v, 32'h0);
        rd(A_DATE, v); check("R10 zero date", v, 32'h0);
        pulse_tick();
        rd(A_TIME, v); check("R10 R1 runs from zero", v, 32'h00000001);
        rd(A_DATE, v); check("R10 date kept", v, 32'h0);
    endtask

    initial begin
        t_reset();
        t_guard();
        t_handshake();
        t_sync();
        t_roll24();
        t_12h();
        t_zero();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule